// File: doc/BRIEF.md
# Multiply/ALU Instruction Cycle Sequencer

This block decides how many instruction cycles one multiply/ALU instruction occupies. It then holds the pipeline for every cycle except the last. The cycle count depends on four inputs, all taken when the instruction is issued: the kind of data transfer, whether the instruction was fetched from the instruction cache, whether an external memory access with programmed wait states is made, and whether the X and Y accesses collide on the same dual-port RAM bank.

The block also turns the input clock into an instruction-cycle enable. In single-rate mode every input clock is an instruction cycle. In half-rate mode an instruction cycle is every second input clock. The sequence moves forward only on enabled clocks. The surrounding pipeline presents an instruction with `issue_i` on a clock where `cyc_en_o` is high and `stall_o` is low. It then holds its state while `stall_o` is high. It retires the instruction in the instruction cycle where `complete_o` is high.

Top module: `instr_cycle_ctrl`

## Requirements
- R1: Transfer kind encoding on `xfer_kind_i`: 0 = none, 1 = ordinary transfer, 2 = RAM write, 3 = dual X/Y read. Kinds 0 and 1 take one instruction cycle, whatever the value of `cache_hit_i`.
- R2: A RAM-write transfer (kind 2) takes two instruction cycles, whether `cache_hit_i` is high or low.
- R3: A dual X/Y read (kind 3) takes two instruction cycles when `cache_hit_i` is low and one when it is high.
- R4: When `ext_access_i` is high, the 4-bit `wait_states_i` value is added once to the instruction's cycle count. When `ext_access_i` is low, `wait_states_i` has no effect.
- R5: When `same_bank_i` is high, one cycle is added to the instruction's cycle count.
- R6: For an instruction of N cycles, `stall_o` is high during the first N-1 instruction cycles. `complete_o` is high during exactly one instruction cycle, the last. The two are never high together.
- R7: With `half_rate_i` low, `cyc_en_o` is high on every clock. With it high, `cyc_en_o` is high on every second clock, and an instruction of N cycles lasts 2N input clocks.
- R8: `issue_i` is accepted only on a clock with `cyc_en_o` high and `stall_o` low. An issue presented while `stall_o` is high is ignored and does not change the running instruction's length.
- R9: After reset, `stall_o` and `complete_o` are low.
- R10: An instruction may be issued in the instruction cycle where the previous one has `complete_o` high, so back-to-back instructions need no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_rate_i | input | 1 | 1 = instruction cycle is two input clocks |
| issue_i | input | 1 | Instruction presented this clock |
| xfer_kind_i | input | 2 | Transfer kind (R1 encoding) |
| cache_hit_i | input | 1 | Instruction came from the cache |
| ext_access_i | input | 1 | Instruction makes an external X or Y access |
| wait_states_i | input | 4 | Programmed wait-state count |
| same_bank_i | input | 1 | X and Y accesses hit the same dual-port bank |
| cyc_en_o | output | 1 | Instruction-cycle enable |
| stall_o | output | 1 | Hold the pipeline this instruction cycle |
| complete_o | output | 1 | Final instruction cycle of the instruction |

## Verification
The assertions check the following on every clock:
- `stall_o` and `complete_o` are never high together.
- The enable cadence holds in each clock mode.
- The outputs hold steady between enabled clocks.
- A stalled cycle is always followed by another stall or by the completing cycle.
- An accepted issue always leads to a busy cycle.

The exact cycle count for each combination of transfer kind, cache residency, wait states and bank conflict can only be shown by the bench's scenarios. The same applies to an issue being ignored during a stall and to back-to-back issue. For each of these the bench measures instruction and input-clock counts at the ports.

// File: rtl/icc_pkg.sv
package icc_pkg;
  typedef enum logic [1:0] {
    XFER_NONE   = 2'd0,
    XFER_PLAIN  = 2'd1,
    XFER_RAM_WR = 2'd2,
    XFER_DUAL   = 2'd3
  } xfer_kind_e;

  // worst case: two base cycles, full wait states, bank penalty
  function automatic int unsigned max_cycles(int unsigned ws_w);
    return 2 + ((1 << ws_w) - 1) + 1;
  endfunction
endpackage

// File: rtl/icc_phase_gen.sv
module icc_phase_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic half_rate_i,
  output logic cyc_en_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          phase_q <= 1'b0;
    else if (half_rate_i) phase_q <= ~phase_q;
    else                  phase_q <= 1'b0;
  end

  assign cyc_en_o = half_rate_i ? phase_q : 1'b1;
endmodule

// File: rtl/icc_cost.sv
module icc_cost
  import icc_pkg::*;
#(
  parameter int unsigned WS_W  = 4,
  parameter int unsigned CNT_W = 5
) (
  input  xfer_kind_e        kind_i,
  input  logic              cache_hit_i,
  input  logic              ext_access_i,
  input  logic [WS_W-1:0]   wait_states_i,
  input  logic              same_bank_i,
  output logic [CNT_W-1:0]  cycles_o
);
  logic [CNT_W-1:0] base, ws_add, bank_add;

  always_comb begin
    unique case (kind_i)
      XFER_RAM_WR: base = CNT_W'(2);
      XFER_DUAL:   base = cache_hit_i ? CNT_W'(1) : CNT_W'(2);
      default:     base = CNT_W'(1);
    endcase
  end

  assign ws_add   = ext_access_i ? CNT_W'(wait_states_i) : '0;
  assign bank_add = same_bank_i ? CNT_W'(1) : '0;
  assign cycles_o = base + ws_add + bank_add;
endmodule

// File: rtl/icc_seq.sv
module icc_seq #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_en_i,
  input  logic             issue_i,
  input  logic [CNT_W-1:0] cycles_i,
  output logic             stall_o,
  output logic             complete_o
);
  // remaining instruction cycles, including the current one
  logic [CNT_W-1:0] left_q;
  logic             ready, accept;

  assign ready  = (left_q <= CNT_W'(1));
  assign accept = cyc_en_i && issue_i && ready;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
    end else if (cyc_en_i) begin
      if (accept)              left_q <= cycles_i;
      else if (left_q != '0)   left_q <= left_q - CNT_W'(1);
    end
  end

  assign stall_o    = !ready;
  assign complete_o = (left_q == CNT_W'(1));
endmodule

// File: rtl/instr_cycle_ctrl.sv
module instr_cycle_ctrl
  import icc_pkg::*;
#(
  parameter int unsigned WS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            half_rate_i,
  input  logic            issue_i,
  input  logic [1:0]      xfer_kind_i,
  input  logic            cache_hit_i,
  input  logic            ext_access_i,
  input  logic [WS_W-1:0] wait_states_i,
  input  logic            same_bank_i,
  output logic            cyc_en_o,
  output logic            stall_o,
  output logic            complete_o
);
  localparam int unsigned CNT_W = $clog2(max_cycles(WS_W) + 1);

  logic [CNT_W-1:0] cycles;
  xfer_kind_e       kind;

  assign kind = xfer_kind_e'(xfer_kind_i);

  icc_phase_gen u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .half_rate_i (half_rate_i),
    .cyc_en_o    (cyc_en_o)
  );

  icc_cost #(.WS_W(WS_W), .CNT_W(CNT_W)) u_cost (
    .kind_i        (kind),
    .cache_hit_i   (cache_hit_i),
    .ext_access_i  (ext_access_i),
    .wait_states_i (wait_states_i),
    .same_bank_i   (same_bank_i),
    .cycles_o      (cycles)
  );

  icc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cyc_en_i   (cyc_en_o),
    .issue_i    (issue_i),
    .cycles_i   (cycles),
    .stall_o    (stall_o),
    .complete_o (complete_o)
  );
endmodule

// File: rtl/icc_checker.sv
module icc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic half_rate_i,
  input logic issue_i,
  input logic cyc_en_o,
  input logic stall_o,
  input logic complete_o
);
  // R6
  stall_complete_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stall_o && complete_o));

  // R7
  single_rate_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_rate_i |-> cyc_en_o);

  // R7
  half_rate_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_rate_i && cyc_en_o) |=> (!cyc_en_o || !half_rate_i));

  // R7
  hold_between_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_en_o |=> ($stable(stall_o) && $stable(complete_o)));

  // R6
  stall_leads_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && cyc_en_o) |=> (stall_o || complete_o));

  // R8
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_en_o && !stall_o && issue_i) |=> (stall_o || complete_o));
endmodule

bind instr_cycle_ctrl icc_checker u_icc_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .half_rate_i (half_rate_i),
  .issue_i     (issue_i),
  .cyc_en_o    (cyc_en_o),
  .stall_o     (stall_o),
  .complete_o  (complete_o)
);

// File: tb/tb_instr_cycle_ctrl.sv
module tb_instr_cycle_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       half_rate = 1'b0;
  logic       issue = 1'b0;
  logic [1:0] kind = 2'd0;
  logic       cache_hit = 1'b0;
  logic       ext = 1'b0;
  logic [3:0] ws = 4'd0;
  logic       same_bank = 1'b0;
  logic       cyc_en, stall, complete;

  int checks = 0;
  int fails  = 0;
  bit prev_done = 1'b0;

  always #4 clk = ~clk;

  instr_cycle_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .half_rate_i(half_rate), .issue_i(issue),
    .xfer_kind_i(kind), .cache_hit_i(cache_hit), .ext_access_i(ext),
    .wait_states_i(ws), .same_bank_i(same_bank),
    .cyc_en_o(cyc_en), .stall_o(stall), .complete_o(complete)
  );

  function automatic int exp_cycles(logic [1:0] k, logic c, logic e, logic [3:0] w, logic b);
    int n;
    case (k)
      2'd2:    n = 2;
      2'd3:    n = c ? 1 : 2;
      default: n = 1;
    endcase
    if (e) n += w;
    if (b) n += 1;
    return n;
  endfunction

  function automatic string req_tag(logic [1:0] k, logic e, logic [3:0] w, logic b, bit spam);
    string s;
    case (k)
      2'd2:    s = "R2";
      2'd3:    s = "R3";
      default: s = "R1";
    endcase
    if (w != 0) s = {s, "/R4"};
    if (b) s = {s, "/R5"};
    if (spam) s = {s, "/R8"};
    return s;
  endfunction

  task automatic check(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_instr(logic [1:0] k, logic c, logic e, logic [3:0] w, logic b, bit spam);
    int n, clks, exp_n;
    string tag;
    if (prev_done)  // R10: ready in the completing cycle
      check(cyc_en && !stall, "R10", int'(cyc_en && !stall), 1, "ready at complete");
    while (!(cyc_en && !stall)) @(negedge clk);
    kind = k; cache_hit = c; ext = e; ws = w; same_bank = b; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    exp_n = exp_cycles(k, c, e, w, b);
    tag = req_tag(k, e, w, b, spam);
    n = 0; clks = 1;
    forever begin
      if (cyc_en) begin
        n++;
        if (complete) break;
        if (!stall) check(1'b0, "R6", 0, 1, "stall before last cycle");
      end
      issue = spam && stall;
      if (spam) begin
        kind = 2'($urandom); ext = 1'b1; ws = 4'd15; same_bank = 1'b1;
      end
      @(negedge clk);
      clks++;
      if (clks > 200) break;
    end
    issue = 1'b0;
    check(n == exp_n, tag, n, exp_n, "instruction cycles");
    check(clks == exp_n * (half_rate ? 2 : 1), "R7", clks, exp_n * (half_rate ? 2 : 1), "input clocks");
    check(complete && !stall, "R6", int'(complete && !stall), 1, "last cycle complete only");
    prev_done = 1'b1;
  endtask

  task automatic idle_gap();
    @(negedge clk);
    while (!cyc_en) @(negedge clk);
    // R6: complete lasts a single instruction cycle
    check(!complete && !stall, "R6", int'(complete || stall), 0, "idle after complete");
    prev_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    // R9
    check(!stall && !complete, "R9", int'(stall || complete), 0, "outputs in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(!stall && !complete, "R9", int'(stall || complete), 0, "idle after reset");
    check(cyc_en, "R7", int'(cyc_en), 1, "single rate enable");

    for (int m = 0; m < 2; m++) begin
      half_rate = m[0];
      idle_gap();
      idle_gap();
      // directed corners
      for (int k = 0; k < 4; k++)
        for (int c = 0; c < 2; c++)
          run_instr(2'(k), 1'(c), 1'b0, 4'd9, 1'b0, 1'b0);
      run_instr(2'd3, 1'b1, 1'b1, 4'd15, 1'b1, 1'b0);
      run_instr(2'd2, 1'b1, 1'b1, 4'd0, 1'b0, 1'b0);
      run_instr(2'd0, 1'b0, 1'b1, 4'd3, 1'b0, 1'b1);
      run_instr(2'd3, 1'b0, 1'b0, 4'd5, 1'b1, 1'b1);
      idle_gap();
      for (int i = 0; i < 60; i++) begin
        run_instr(2'($urandom), 1'($urandom), 1'($urandom), 4'($urandom),
                  1'($urandom), ($urandom % 4) == 0);
        if (($urandom % 5) == 0) idle_gap();
      end
      idle_gap();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule